// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block turns a stream of left/right sample pairs into a serial audio frame on one data line, together with a bit clock and a word-select signal. The frame is a run of bit slots whose count is programmable. Each channel's first bit can be placed at any slot. A bit-order flag chooses whether the most or least significant bit goes first. A stop setting limits how many bits of each sample are sent, and every slot that carries no sample bit is zero. Word-select can be a half-frame square wave or a one-slot pulse, with either polarity. Serial data and word-select can be launched on either edge of the bit clock. Each bit slot lasts two system clock cycles: the bit clock is low for the first and high for the second.

Sample pairs arrive over a valid/ready interface. A pair moves only in a cycle where both `in_valid` and `in_ready` are high. While `in_valid` is high and `in_ready` is low, the source must hold `in_left`/`in_right` stable. The block holds one waiting pair and raises `in_ready` only while that holding slot is empty. Fetching starts with the first word-select transition after enable, so the first frame after enable always carries zero data. If no pair is waiting when a frame starts, the previous pair is sent again and `underrun_o` pulses. Configuration inputs are captured at enable and at each frame boundary, so a frame never mixes two settings.

Top module: `ser_audio_tx`

## Requirements
- R1: While enabled, `sck_o` is low for one clock and high for the next in every bit slot, and a frame holds `cfg_last_slot + 1` slots numbered from 0.
- R2: With MSB-first order (`cfg_lsb_first` = 0), slot `cfg_left_slot + k` carries left-sample bit `SAMPLE_W-1-k` for k from 0 to `cfg_stop`.
- R3: The right sample is placed the same way starting at `cfg_right_slot`. When both channels would carry a bit in the same slot, the left bit is sent.
- R4: With LSB-first order (`cfg_lsb_first` = 1), slot `start + k` carries sample bit k instead.
- R5: Sample offsets beyond `cfg_stop`, and slots outside both channel windows, carry 0.
- R6: In square mode (`cfg_ws_pulse` = 0), word-select is active for slots below `(cfg_last_slot+1)/2` and inactive for the rest. Active is low when `cfg_ws_pol` = 0 and high when `cfg_ws_pol` = 1.
- R7: In pulse mode (`cfg_ws_pulse` = 1), word-select is active only in slot 0, using the same polarity rule as R6.
- R8: With `cfg_launch_rise` = 0, a slot's data and word-select appear in the cycle where `sck_o` goes low. With `cfg_launch_rise` = 1, they appear in the cycle where `sck_o` goes high and are held through the following low half.
- R9: The first frame after enable sends zeros. `in_ready` is high only while enabled, with no pair waiting, and outside the last half-slot of a frame. A pair taken during a frame is sent in the next frame.
- R10: If no pair is waiting at a frame boundary, the previous pair is sent again and `underrun_o` is high for exactly the first cycle of the new frame.
- R11: All `cfg_*` inputs except the idle word-select level are captured only when enable rises and at frame boundaries.
- R12: While disabled or in reset, `sck_o` and `sd_o` are 0, `in_ready` is 0, and `ws_o` sits at the inactive level `!cfg_ws_pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Transmit enable |
| cfg_last_slot | input | SLOT_W | Frame length minus one |
| cfg_left_slot | input | SLOT_W | Slot of the left sample's first bit |
| cfg_right_slot | input | SLOT_W | Slot of the right sample's first bit |
| cfg_stop | input | clog2(SAMPLE_W) | Last sample-bit offset sent per channel |
| cfg_lsb_first | input | 1 | 1 sends least significant bit first |
| cfg_ws_pol | input | 1 | 1 makes word-select active high |
| cfg_ws_pulse | input | 1 | 1 selects a one-slot word-select pulse |
| cfg_launch_rise | input | 1 | 1 launches data on the bit-clock rising edge |
| in_valid | input | 1 | Sample pair available |
| in_ready | output | 1 | Block accepts a pair this cycle |
| in_left | input | SAMPLE_W | Left sample |
| in_right | input | SAMPLE_W | Right sample |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word-select |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-cycle pulse: frame started with no new pair |

## Verification
A wrong slot counter or frame length moves the word-select edges. This shows on `ws_o` within one frame, and the data bits shift along with it. A holding register that loses or repeats a pair shows as wrong `sd_o` bits in the next frame and as `in_ready` staying high or low for the wrong cycles. A mis-timed launch register makes `sd_o` change at the wrong bit-clock phase within a single slot. The bench model predicts every output pin on every clock, so any such error shows up at the first cycle where it changes a pin.

// File: rtl/ao_pkg.sv
package ao_pkg;
  typedef enum logic {
    ORDER_MSB = 1'b0,
    ORDER_LSB = 1'b1
  } bit_order_e;

  typedef enum logic {
    WS_SQUARE = 1'b0,
    WS_PULSE  = 1'b1
  } ws_style_e;
endpackage

// File: rtl/ao_frame_timer.sv
// Bit-slot and half-slot counter; two clocks per slot, low half first.
module ao_frame_timer #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [SLOT_W-1:0] last_slot,
  output logic              phase,
  output logic [SLOT_W-1:0] slot,
  output logic              boundary
);
  assign boundary = run && phase && (slot == last_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      slot  <= '0;
    end else if (!run) begin
      phase <= 1'b0;
      slot  <= '0;
    end else if (!phase) begin
      phase <= 1'b1;
    end else begin
      phase <= 1'b0;
      slot  <= (slot == last_slot) ? '0 : slot + SLOT_W'(1);
    end
  end
endmodule

// File: rtl/ao_pair_buf.sv
// One waiting pair plus the pair on air; repeats on underrun.
module ao_pair_buf #(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                act,
  input  logic                boundary,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                in_ready,
  output logic [SAMPLE_W-1:0] cur_left,
  output logic [SAMPLE_W-1:0] cur_right,
  output logic                underrun
);
  logic                have_q;
  logic [SAMPLE_W-1:0] nxt_left, nxt_right;

  assign in_ready = act && !have_q && !boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q    <= 1'b0;
      nxt_left  <= '0;
      nxt_right <= '0;
      cur_left  <= '0;
      cur_right <= '0;
      underrun  <= 1'b0;
    end else begin
      underrun <= 1'b0;
      if (start) begin
        have_q    <= 1'b0;
        cur_left  <= '0;
        cur_right <= '0;
      end else if (act) begin
        if (boundary) begin
          if (have_q) begin
            cur_left  <= nxt_left;
            cur_right <= nxt_right;
            have_q    <= 1'b0;
          end else begin
            underrun <= 1'b1;
          end
        end else if (in_valid && in_ready) begin
          nxt_left  <= in_left;
          nxt_right <= in_right;
          have_q    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ao_slot_mux.sv
// Combinational slot decoder: data bit and word-select level of a slot.
module ao_slot_mux #(
  parameter int SAMPLE_W = 32,
  parameter int SLOT_W   = 8
) (
  input  logic [SLOT_W-1:0]           slot,
  input  logic [SLOT_W-1:0]           last_slot,
  input  logic [SLOT_W-1:0]           left_slot,
  input  logic [SLOT_W-1:0]           right_slot,
  input  logic [$clog2(SAMPLE_W)-1:0] stop,
  input  logic                        lsb_first,
  input  logic                        ws_pol,
  input  logic                        ws_pulse,
  input  logic [SAMPLE_W-1:0]         left,
  input  logic [SAMPLE_W-1:0]         right,
  output logic                        sd,
  output logic                        ws
);
  localparam int SW = $clog2(SAMPLE_W);
  localparam int CW = ((SLOT_W > SW) ? SLOT_W : SW) + 1;

  logic [CW-1:0]   stop_x, off_l, off_r;
  logic            hit_l, hit_r;
  logic [SW-1:0]   idx_l, idx_r;
  logic [SLOT_W:0] half;
  logic            active;

  assign stop_x = CW'(stop);
  assign off_l  = CW'(slot) - CW'(left_slot);
  assign off_r  = CW'(slot) - CW'(right_slot);
  assign hit_l  = (slot >= left_slot)  && (off_l <= stop_x);
  assign hit_r  = (slot >= right_slot) && (off_r <= stop_x);
  assign idx_l  = lsb_first ? off_l[SW-1:0] : SW'(SAMPLE_W - 1) - off_l[SW-1:0];
  assign idx_r  = lsb_first ? off_r[SW-1:0] : SW'(SAMPLE_W - 1) - off_r[SW-1:0];

  always_comb begin
    if (hit_l)      sd = left[idx_l];
    else if (hit_r) sd = right[idx_r];
    else            sd = 1'b0;
  end

  assign half   = ({1'b0, last_slot} + {{SLOT_W{1'b0}}, 1'b1}) >> 1;
  assign active = ws_pulse ? (slot == '0) : ({1'b0, slot} < half);
  assign ws     = active ^ ~ws_pol;
endmodule

// File: rtl/ser_audio_tx.sv
module ser_audio_tx #(
  parameter int SAMPLE_W = 32,
  parameter int SLOT_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [SLOT_W-1:0]           cfg_last_slot,
  input  logic [SLOT_W-1:0]           cfg_left_slot,
  input  logic [SLOT_W-1:0]           cfg_right_slot,
  input  logic [$clog2(SAMPLE_W)-1:0] cfg_stop,
  input  logic                        cfg_lsb_first,
  input  logic                        cfg_ws_pol,
  input  logic                        cfg_ws_pulse,
  input  logic                        cfg_launch_rise,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [SAMPLE_W-1:0]         in_left,
  input  logic [SAMPLE_W-1:0]         in_right,
  output logic                        sck_o,
  output logic                        ws_o,
  output logic                        sd_o,
  output logic                        underrun_o
);
  import ao_pkg::*;
  localparam int SW = $clog2(SAMPLE_W);

  logic              run_q, start, act, boundary, phase;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] last_q, lpos_q, rpos_q;
  logic [SW-1:0]     stop_q;
  bit_order_e        order_q;
  ws_style_e         style_q;
  logic              pol_q, launch_q;
  logic [SAMPLE_W-1:0] cur_left, cur_right;
  logic              sd_now, ws_now, sd_dly, ws_dly;

  assign start = en && !run_q;
  assign act   = en && run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= en;
  end

  // Settings are captured only at enable and at frame boundaries.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q   <= '0;
      lpos_q   <= '0;
      rpos_q   <= '0;
      stop_q   <= '0;
      order_q  <= ORDER_MSB;
      style_q  <= WS_SQUARE;
      pol_q    <= 1'b0;
      launch_q <= 1'b0;
    end else if (start || (boundary && en)) begin
      last_q   <= cfg_last_slot;
      lpos_q   <= cfg_left_slot;
      rpos_q   <= cfg_right_slot;
      stop_q   <= cfg_stop;
      order_q  <= bit_order_e'(cfg_lsb_first);
      style_q  <= ws_style_e'(cfg_ws_pulse);
      pol_q    <= cfg_ws_pol;
      launch_q <= cfg_launch_rise;
    end
  end

  ao_frame_timer #(.SLOT_W(SLOT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .last_slot(last_q),
    .phase    (phase),
    .slot     (slot),
    .boundary (boundary)
  );

  ao_pair_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .act      (act),
    .boundary (boundary),
    .in_valid (in_valid),
    .in_left  (in_left),
    .in_right (in_right),
    .in_ready (in_ready),
    .cur_left (cur_left),
    .cur_right(cur_right),
    .underrun (underrun_o)
  );

  ao_slot_mux #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_mux (
    .slot      (slot),
    .last_slot (last_q),
    .left_slot (lpos_q),
    .right_slot(rpos_q),
    .stop      (stop_q),
    .lsb_first (order_q == ORDER_LSB),
    .ws_pol    (pol_q),
    .ws_pulse  (style_q == WS_PULSE),
    .left      (cur_left),
    .right     (cur_right),
    .sd        (sd_now),
    .ws        (ws_now)
  );

  // Rising-edge launch: hold the high-half value through the next low half.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_dly <= 1'b0;
      ws_dly <= 1'b1;
    end else if (start) begin
      sd_dly <= 1'b0;
      ws_dly <= ~cfg_ws_pol;
    end else if (run_q && phase) begin
      sd_dly <= sd_now;
      ws_dly <= ws_now;
    end
  end

  always_comb begin
    if (!run_q) begin
      sck_o = 1'b0;
      sd_o  = 1'b0;
      ws_o  = ~cfg_ws_pol;
    end else begin
      sck_o = phase;
      if (launch_q && !phase) begin
        sd_o = sd_dly;
        ws_o = ws_dly;
      end else begin
        sd_o = sd_now;
        ws_o = ws_now;
      end
    end
  end
endmodule

// File: rtl/ser_audio_tx_chk.sv
module ser_audio_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic run_q,
  input logic launch_q,
  input logic sck_o,
  input logic sd_o,
  input logic ws_o,
  input logic in_valid,
  input logic in_ready,
  input logic underrun_o
);
  AST_SCK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> (sck_o != $past(sck_o))); // R1
  AST_HOLD_FALL_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && $rose(sck_o) && !launch_q && !$past(launch_q))
      |-> ($stable(sd_o) && $stable(ws_o))); // R8
  AST_HOLD_RISE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && $fell(sck_o) && launch_q && $past(launch_q))
      |-> ($stable(sd_o) && $stable(ws_o))); // R8
  AST_ONE_PAIR_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R9
  AST_UNDERRUN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> !underrun_o); // R10
  AST_UNDERRUN_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> !sck_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!sck_o && !sd_o && !in_ready)); // R12
endmodule

bind ser_audio_tx ser_audio_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_q     (run_q),
  .launch_q  (launch_q),
  .sck_o     (sck_o),
  .sd_o      (sd_o),
  .ws_o      (ws_o),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .underrun_o(underrun_o)
);

// File: tb/tb_ser_audio_tx.sv
module tb_ser_audio_tx;
  localparam int W = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b0;
  logic [7:0] c_last = 8'd63, c_lpos = 8'd0, c_rpos = 8'd32;
  logic [4:0] c_stop = 5'd31;
  logic c_lsb = 1'b0, c_pol = 1'b0, c_pulse = 1'b0, c_rise = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_left = '0, in_right = '0;
  logic in_ready, sck_o, ws_o, sd_o, underrun_o;

  int n_tests = 0, n_fail = 0, und_seen = 0;
  bit src_on = 1'b0;
  logic [2*W-1:0] srcq[$];

  // behavioural reference state
  bit m_run = 0, m_ph = 0, m_have = 0, m_und = 0, m_dsd = 0, m_dws = 1;
  int m_slot = 0;
  logic [W-1:0] m_l = '0, m_r = '0, m_nl = '0, m_nr = '0;
  int k_last = 0, k_lpos = 0, k_rpos = 0, k_stop = 0;
  bit k_lsb = 0, k_pol = 0, k_pulse = 0, k_rise = 0;

  ser_audio_tx #(.SAMPLE_W(W), .SLOT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_last_slot(c_last), .cfg_left_slot(c_lpos), .cfg_right_slot(c_rpos),
    .cfg_stop(c_stop), .cfg_lsb_first(c_lsb), .cfg_ws_pol(c_pol),
    .cfg_ws_pulse(c_pulse), .cfg_launch_rise(c_rise),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o), .underrun_o(underrun_o)
  );

  function automatic bit f_sd(int s, logic [W-1:0] l, logic [W-1:0] r);
    int o;
    o = s - k_lpos;
    if (o >= 0 && o <= k_stop) return k_lsb ? l[o] : l[W-1-o];
    o = s - k_rpos;
    if (o >= 0 && o <= k_stop) return k_lsb ? r[o] : r[W-1-o];
    return 1'b0;
  endfunction

  function automatic bit f_ws(int s);
    bit act;
    act = k_pulse ? (s == 0) : (s < (k_last + 1) / 2);
    return act ^ !k_pol;
  endfunction

  function automatic bit exp_ready();
    return m_run && en && !m_have && !(m_ph && m_slot == k_last);
  endfunction

  task automatic latch_cfg();
    k_last = c_last; k_lpos = c_lpos; k_rpos = c_rpos; k_stop = c_stop;
    k_lsb = c_lsb; k_pol = c_pol; k_pulse = c_pulse; k_rise = c_rise;
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    bit pop, rdy;
    rdy = exp_ready();
    pop = in_valid && rdy;
    if (!rst_n || !en) begin
      m_run = 0; m_und = 0;
    end else if (!m_run) begin
      m_run = 1; m_ph = 0; m_slot = 0; latch_cfg();
      m_l = '0; m_r = '0; m_have = 0; m_und = 0; m_dsd = 0; m_dws = !c_pol;
    end else begin
      m_und = 0;
      if (!m_ph) m_ph = 1;
      else begin
        m_dsd = f_sd(m_slot, m_l, m_r);
        m_dws = f_ws(m_slot);
        m_ph = 0;
        if (m_slot == k_last) begin
          m_slot = 0;
          latch_cfg();
          if (m_have) begin m_l = m_nl; m_r = m_nr; m_have = 0; end
          else m_und = 1;
        end else m_slot++;
      end
      if (pop) begin
        m_nl = in_left; m_nr = in_right; m_have = 1;
        void'(srcq.pop_front());
      end
    end
  end

  // source: holds the queue head while valid and not ready
  always @(posedge clk) begin
    #1;
    if (src_on && srcq.size() > 0) begin
      in_valid = 1'b1;
      {in_left, in_right} = srcq[0];
    end else in_valid = 1'b0;
  end

  always @(negedge clk) begin : compare
    bit e_sck, e_sd, e_ws;
    if (!m_run) begin
      e_sck = 0; e_sd = 0; e_ws = !c_pol;
      chk(sck_o, e_sck, "R12 idle bit clock");
      chk(sd_o, e_sd, "R12 idle data");
      chk(ws_o, e_ws, "R12 idle word-select");
    end else begin
      e_sck = m_ph;
      if (k_rise && !m_ph) begin e_sd = m_dsd; e_ws = m_dws; end
      else begin e_sd = f_sd(m_slot, m_l, m_r); e_ws = f_ws(m_slot); end
      chk(sck_o, e_sck, "R1 bit clock phase");
      chk(sd_o, e_sd, "R2 R3 R4 R5 R8 R11 serial data");
      chk(ws_o, e_ws, "R6 R7 R8 R11 word-select");
    end
    chk(in_ready, exp_ready(), "R9 in_ready");
    chk(underrun_o, m_und, "R10 underrun");
    if (underrun_o === 1'b1) und_seen++;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    summary();
  end

  initial begin
    tick(3);
    // R12: reset state at the ports
    chk(sck_o, 1'b0, "R12 reset sck");
    chk(in_ready, 1'b0, "R12 reset ready");
    chk(ws_o, 1'b1, "R12 reset ws idle level");
    rst_n = 1'b1;
    tick(2);

    // R2 R6 R9 R10: 64-slot frame, MSB first, square ws, falling launch
    und_seen = 0;
    srcq.push_back({32'hA5C3_0F96, 32'h1234_5678});
    srcq.push_back({32'h8000_0001, 32'hFEDC_BA98});
    src_on = 1'b1;
    en = 1'b1;
    tick(128 * 4 + 10);
    n_tests++;
    if (und_seen != 2) begin
      n_fail++;
      $display("FAIL R10 underrun count: got %0d expected 2", und_seen);
    end

    // R12: disabled with active-high polarity, ws rests low
    en = 1'b0;
    c_pol = 1'b1;
    tick(4);
    chk(ws_o, 1'b0, "R12 idle ws follows polarity");

    // R4 R5 R7 R8: LSB first, stop at 15, pulse ws, rising launch, slow source
    c_last = 8'd47; c_lpos = 8'd1; c_rpos = 8'd25; c_stop = 5'd15;
    c_lsb = 1'b1; c_pulse = 1'b1; c_rise = 1'b1;
    srcq.push_back({32'h0000_C3A5, 32'h5A5A_F00F});
    srcq.push_back({32'hDEAD_BEEF, 32'h0F0F_1234});
    srcq.push_back({32'h7777_0001, 32'h8888_8000});
    src_on = 1'b0;
    en = 1'b1;
    tick(96 + 37);
    src_on = 1'b1;
    tick(96 * 4);

    // R3: overlapping windows, left wins; R11: mid-frame settings change
    en = 1'b0;
    tick(2);
    c_last = 8'd39; c_lpos = 8'd0; c_rpos = 8'd10; c_stop = 5'd31;
    c_lsb = 1'b0; c_pol = 1'b0; c_pulse = 1'b0; c_rise = 1'b1;
    srcq.push_back({32'hF0F0_F0F0, 32'hFFFF_FFFF});
    srcq.push_back({32'h0000_0000, 32'hFFFF_FFFF});
    srcq.push_back({32'h1357_9BDF, 32'h2468_ACE0});
    en = 1'b1;
    tick(80 * 2 + 23);
    c_lpos = 8'd5; c_last = 8'd49; c_pulse = 1'b1; c_rise = 1'b0;
    tick(100 * 3);

    // R9: disable mid-frame and restart, first frame again carries zeros
    en = 1'b0;
    tick(1);
    srcq.push_back({32'hCAFE_F00D, 32'h0BAD_C0DE});
    en = 1'b1;
    tick(100 * 3);
    en = 1'b0;
    tick(4);
    summary();
  end
endmodule